// File: doc/BRIEF.md
# Coprocessor Control and Interrupt Register

A single 16-bit control/status register that a host processor uses to manage an attached coprocessor. It collects four interrupt sources into sticky pending bits and combines them, through per-source enables, into one host interrupt line. The sources are audio DMA completion, auxiliary-memory DMA completion, the coprocessor's own interrupt and coprocessor DMA completion. The same word also carries a held halt control and two self-clearing request bits. One request resets the coprocessor; the other interrupts it.

Sources report through single-cycle event inputs. The host clears a pending bit by writing 1 to it. A write of 0 to a pending bit leaves it alone, so a read-modify-write that changes only enables or halt cannot lose a pending interrupt. The coprocessor and the DMA engines live outside this block.

Top module: `cop_ctrl_reg`

## Requirements
- R1: After reset, `rd_data_o`, `host_irq_o`, `halt_o`, `cop_reset_o` and `cop_irq_o` are all 0.
- R2: Bits 2, 4, 6 and 8 are read/write controls. A write sets each of them to the written value, and the new value reads back after the write edge. Bits 0, 1 and 10 to 15 always read 0.
- R3: An event on `evt_i[k]` sets a pending bit, visible after that edge. The mapping is: k=0 audio to bit 3, k=1 auxiliary memory to bit 5, k=2 coprocessor to bit 7, k=3 coprocessor DMA to bit 9.
- R4: Writing 1 to a pending bit (3, 5, 7 or 9) clears it. Writing 0 to it leaves it unchanged.
- R5: If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `host_irq_o` = (b3 & b4) | (b5 & b6) | ((b7 | b9) & b8), where bN is bit N of the register. Bit 8 enables both coprocessor-related sources.
- R7: `halt_o` equals bit 2 of the register and holds between writes.
- R8: A write with bit 0 = 1 drives `cop_reset_o` high for exactly the one cycle after the write edge.
- R9: A write with bit 1 = 1 drives `cop_irq_o` high for exactly the one cycle after the write edge.
- R10: With `wr_en_i` low, `wr_data_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 16 | Host write data |
| evt_i | input | 4 | Source events: 0 audio, 1 aux memory, 2 coprocessor, 3 coprocessor DMA |
| rd_data_o | output | 16 | Register read value |
| host_irq_o | output | 1 | Combined interrupt to host |
| halt_o | output | 1 | Coprocessor halt |
| cop_reset_o | output | 1 | One-cycle coprocessor reset pulse |
| cop_irq_o | output | 1 | One-cycle interrupt pulse to coprocessor |

## Verification
Every result is due one clock edge after its stimulus:
- read value, halt and the host interrupt, once the register has updated;
- the reset and coprocessor-interrupt pulses, which are high for that single cycle and low after the following edge.

The bench drives inputs at the falling edge and queues the model's expected output for the next rising edge. A monitor samples 5 ns after each rising edge and pops exactly one item per edge. A pulse that lasts longer than one cycle therefore shows up as a mismatch, and so does one that arrives late.

// File: rtl/cop_ctrl_pkg.sv
package cop_ctrl_pkg;
  localparam int REG_W    = 16;
  localparam int N_SRC    = 4;
  localparam int BIT_RST  = 0;
  localparam int BIT_CIRQ = 1;
  localparam int BIT_HALT = 2;
  // source order: audio, aux memory, coprocessor, coprocessor dma
  localparam int STAT_POS [N_SRC] = '{3, 5, 7, 9};
  localparam int MASK_POS [N_SRC] = '{4, 6, 8, 8};

  function automatic logic [REG_W-1:0] ctl_bits();
    logic [REG_W-1:0] m;
    m = '0;
    m[BIT_HALT] = 1'b1;
    for (int i = 0; i < N_SRC; i++) m[MASK_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_src_bit.sv
module irq_src_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic pend_o,
  output logic req_o
);
  logic pend_q;

  // event has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (evt_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign req_o  = pend_q & mask_i;
endmodule

// File: rtl/req_pulse.sv
module req_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= trig_i;
  end
endmodule

// File: rtl/cop_ctrl_reg.sv
module cop_ctrl_reg
  import cop_ctrl_pkg::*;
#(
  parameter int W = REG_W,
  parameter int NS = N_SRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [NS-1:0] evt_i,
  output logic [W-1:0]  rd_data_o,
  output logic          host_irq_o,
  output logic          halt_o,
  output logic          cop_reset_o,
  output logic          cop_irq_o
);
  localparam logic [W-1:0] CTL_MASK = W'(ctl_bits());

  logic [W-1:0]  ctl_q;
  logic [NS-1:0] pend, req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctl_q <= '0;
    else if (wr_en_i) ctl_q <= wr_data_i & CTL_MASK;
  end

  for (genvar i = 0; i < NS; i++) begin : g_src
    irq_src_bit u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[i]),
      .clr_i  (wr_en_i & wr_data_i[STAT_POS[i]]),
      .mask_i (ctl_q[MASK_POS[i]]),
      .pend_o (pend[i]),
      .req_o  (req[i])
    );
  end

  req_pulse u_rst_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (wr_en_i & wr_data_i[BIT_RST]),
    .pulse_o (cop_reset_o)
  );

  req_pulse u_cirq_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (wr_en_i & wr_data_i[BIT_CIRQ]),
    .pulse_o (cop_irq_o)
  );

  always_comb begin
    rd_data_o = ctl_q;
    for (int i = 0; i < NS; i++) rd_data_o[STAT_POS[i]] = pend[i];
  end

  assign host_irq_o = |req;
  assign halt_o     = ctl_q[BIT_HALT];
endmodule

// File: rtl/cop_ctrl_reg_chk.sv
module cop_ctrl_reg_chk
  import cop_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [N_SRC-1:0]  evt_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              host_irq_o,
  input logic              halt_o,
  input logic              cop_reset_o,
  input logic              cop_irq_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    // R3
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> rd_data_o[STAT_POS[i]]);
    // R4
    w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[STAT_POS[i]] && !evt_i[i]) |=> !rd_data_o[STAT_POS[i]]);
    // R4
    w0_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(wr_en_i && wr_data_i[STAT_POS[i]]) && !evt_i[i]) |=> $stable(rd_data_o[STAT_POS[i]]));
  end

  // R6
  irq_combine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o == ((rd_data_o[3] & rd_data_o[4]) | (rd_data_o[5] & rd_data_o[6]) |
                   ((rd_data_o[7] | rd_data_o[9]) & rd_data_o[8])));
  // R7
  halt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (halt_o == $past(wr_data_i[BIT_HALT])));
  // R8
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[BIT_RST]) |=> cop_reset_o);
  // R8
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[BIT_RST]) |=> !cop_reset_o);
  // R9
  cirq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[BIT_CIRQ]) |=> cop_irq_o);
  // R2
  zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1:0] == 2'b00 && rd_data_o[15:10] == 6'd0);
endmodule

bind cop_ctrl_reg cop_ctrl_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .evt_i       (evt_i),
  .rd_data_o   (rd_data_o),
  .host_irq_o  (host_irq_o),
  .halt_o      (halt_o),
  .cop_reset_o (cop_reset_o),
  .cop_irq_o   (cop_irq_o)
);

// File: tb/cop_ctrl_reg_bench.sv
module cop_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [3:0]  evt = '0;
  logic [15:0] rd_data;
  logic        host_irq, halt, cop_rst, cop_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [19:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  // bench model state
  logic [3:0]  m_pend = '0;
  logic [15:0] m_ctl  = '0;
  localparam int SPOS [4] = '{3, 5, 7, 9};
  localparam int MPOS [4] = '{4, 6, 8, 8};

  always #10 clk = ~clk;

  cop_ctrl_reg u_cop_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .evt_i(evt),
    .rd_data_o(rd_data), .host_irq_o(host_irq), .halt_o(halt),
    .cop_reset_o(cop_rst), .cop_irq_o(cop_irq)
  );

  task automatic step(input logic we, input logic [15:0] d, input logic [3:0] ev, input string tag);
    logic [15:0] rd;
    logic irq;
    item_t it;
    @(negedge clk);
    wr_en = we; wr_data = d; evt = ev;
    for (int i = 0; i < 4; i++)
      m_pend[i] = ev[i] | (m_pend[i] & ~(we & d[SPOS[i]]));
    if (we) m_ctl = d & 16'h0154;
    rd = m_ctl;
    irq = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd[SPOS[i]] = m_pend[i];
      irq = irq | (m_pend[i] & m_ctl[MPOS[i]]);
    end
    it.exp = {rd, irq, m_ctl[2], we & d[0], we & d[1]};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: one item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [19:0] act;
        it  = sb_q.pop_front();
        act = {rd_data, host_irq, halt, cop_rst, cop_irq};
        n_tests++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%05h expected=%05h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    #55 rst_n = 1'b1;
    step(0, 16'h0000, 4'b0000, "R1 reset state");
    step(0, 16'hFFFF, 4'b0000, "R10 write ignored without strobe");
    step(1, 16'hFFFC, 4'b0000, "R2 controls readback, fixed-zero bits");
    step(1, 16'h0000, 4'b0000, "R2 controls cleared");
    step(0, 16'h0000, 4'b0001, "R3 audio event sets bit3");
    step(0, 16'h0000, 4'b0010, "R3 aux event sets bit5");
    step(0, 16'h0000, 4'b0100, "R3 cop event sets bit7");
    step(0, 16'h0000, 4'b1000, "R3 dma event sets bit9");
    step(1, 16'h0000, 4'b0000, "R4 write 0 keeps pending");
    step(1, 16'h0010, 4'b0000, "R6 audio mask raises irq");
    step(1, 16'h0040, 4'b0000, "R6 aux mask only");
    step(1, 16'h0100, 4'b0000, "R6 shared mask for bits 7 and 9");
    step(1, 16'h0188, 4'b0000, "R4 clear audio and cop");
    step(1, 16'h0300, 4'b0000, "R4 clear dma, irq drops");
    step(1, 16'h0020, 4'b0010, "R5 event beats clear");
    step(1, 16'h0060, 4'b0000, "R4 clear aux with mask on");
    step(1, 16'h0004, 4'b0000, "R7 halt set");
    step(0, 16'h0000, 4'b0000, "R7 halt held");
    step(1, 16'h0005, 4'b0000, "R8 reset pulse");
    step(0, 16'h0000, 4'b0000, "R8 reset pulse ends");
    step(1, 16'h0002, 4'b0000, "R9 cop irq pulse, halt released");
    step(0, 16'h0000, 4'b0000, "R9 cop irq pulse ends");
    step(1, 16'h0003, 4'b0000, "R8 R9 both pulses");
    step(1, 16'h0003, 4'b0000, "R8 back-to-back pulse");
    step(0, 16'h0000, 4'b0000, "R8 pulse ends after repeat");
    step(0, 16'hFFFF, 4'b1111, "R10 events only");
    step(0, 16'h0000, 4'b0000, "R10 idle");
    repeat (3) @(negedge clk);
    wr_en = 1'b0; evt = '0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule